// File: doc/BRIEF.md
# Auto-Incrementing Palette Loader

This block holds a 256-entry colour lookup table, each entry made of separate 8-bit red, green and blue values, and lets a host fill it through a small write-only register window. The host first writes a starting entry number to the index register. It then streams colour components to the colour register. Successive colour writes land in red, then green, then blue of the current entry. After each blue write the index moves on to the next entry, so a whole table can be loaded with one index write followed by a stream of component writes.

The display side reads the table through a separate read port: an entry number goes in and that entry's three components come out combinationally. Reset gives a black table whose last entry is white, so a screen with a known foreground and background works before software loads any colours.

Top module: `palette_dac_port`

## Requirements
- R1: A write to byte offset 0x0 of the window loads the current entry index from bits 31:24 of the write data.
- R2: A write to offset 0x0 also returns the component sequencer to red, so the next colour write goes to red even if a triple was left unfinished.
- R3: Writes to byte offset 0x4 store bits 31:24 of the write data into red, then green, then blue of the current entry, and this order repeats.
- R4: The blue write advances the entry index by one, from 255 back to 0, and the next colour write goes to red of the new entry.
- R5: After reset every entry reads (0,0,0) except entry 255, which reads (255,255,255).
- R6: Each component write is visible on the read port from the cycle after its write strobe, without waiting for the triple to complete, and leaves the entry's other components unchanged.
- R7: Writes to any offset of the 16-byte window other than 0x0 and 0x4, and cycles with the write strobe low, change neither the table, the index nor the sequencer phase.
- R8: The read port returns the red, green and blue values of the entry chosen by the read index in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register window |
| wr_addr | input | 4 | Byte offset inside the 16-byte window |
| wr_data | input | 32 | Write data; bits 31:24 carry the index or component |
| rd_idx | input | 8 | Entry number for the read port |
| rd_red | output | 8 | Red component of the selected entry |
| rd_green | output | 8 | Green component of the selected entry |
| rd_blue | output | 8 | Blue component of the selected entry |

## Verification
The hardest states to reach from the ports are the wrap of the index from 255 to 0 inside a stream of colour writes, and an index write that cuts a triple short. Neither the index nor the phase is visible at the ports. The bench therefore loads index 255 directly and streams two complete triples, so that the second triple must appear in entry 0. It also abandons a triple after its red write by writing the index again, and checks where the following components land. Ignored offsets are exercised by a sweep of all fourteen unused offsets between two colour writes. The phase and index are then shown to be untouched by where the next component lands.

// File: rtl/palette_dac_port.sv
module palette_dac_port #(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] IDX_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] COL_OFF = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [COMP_W-1:0] rd_red,
  output logic [COMP_W-1:0] rd_green,
  output logic [COMP_W-1:0] rd_blue
);
  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_t;

  logic [COMP_W-1:0] red_a [ENTRIES];
  logic [COMP_W-1:0] grn_a [ENTRIES];
  logic [COMP_W-1:0] blu_a [ENTRIES];
  logic [IDX_W-1:0]  idx_q;
  phase_t            phase_q;

  logic sel_idx, sel_col;
  logic [COMP_W-1:0] comp;
  logic [IDX_W-1:0]  new_idx;
  logic unused_low;

  assign sel_idx = wr_en && (wr_addr == IDX_OFF);
  assign sel_col = wr_en && (wr_addr == COL_OFF);
  assign comp    = wr_data[DATA_W-1 -: COMP_W];
  assign new_idx = wr_data[DATA_W-1 -: IDX_W];
  assign unused_low = ^wr_data[DATA_W-COMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (sel_idx) begin
      idx_q   <= new_idx;
      phase_q <= PH_RED;
    end else if (sel_col) begin
      case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        red_a[i] <= (i == ENTRIES-1) ? '1 : '0;
        grn_a[i] <= (i == ENTRIES-1) ? '1 : '0;
        blu_a[i] <= (i == ENTRIES-1) ? '1 : '0;
      end
    end else if (sel_col) begin
      case (phase_q)
        PH_RED:  red_a[idx_q] <= comp;
        PH_GRN:  grn_a[idx_q] <= comp;
        default: blu_a[idx_q] <= comp;
      endcase
    end
  end

  assign rd_red   = red_a[rd_idx];
  assign rd_green = grn_a[rd_idx];
  assign rd_blue  = blu_a[rd_idx];
endmodule

// File: rtl/palette_dac_port_chk.sv
module palette_dac_port_chk #(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] IDX_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] COL_OFF = 4'h4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [COMP_W-1:0] rd_red,
  input logic [COMP_W-1:0] rd_green,
  input logic [COMP_W-1:0] rd_blue,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q
);
  logic is_idx, is_col, other;
  assign is_idx = wr_en && (wr_addr == IDX_OFF);
  assign is_col = wr_en && (wr_addr == COL_OFF);
  assign other  = !is_idx && !is_col;

  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_idx |=> idx_q == $past(wr_data[DATA_W-1 -: IDX_W]));

  assert_phase_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_idx |=> phase_q == 2'd0);

  assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && phase_q == 2'd0) |=> (phase_q == 2'd1 && $stable(idx_q)));

  assert_green_to_blue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && phase_q == 2'd1) |=> (phase_q == 2'd2 && $stable(idx_q)));

  assert_blue_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && phase_q == 2'd2) |=> (phase_q == 2'd0 && idx_q == IDX_W'($past(idx_q) + 1'b1)));

  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  assert_red_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && phase_q == 2'd0 && rd_idx == idx_q) |=>
      (rd_idx != $past(rd_idx) || (rd_red == $past(wr_data[DATA_W-1 -: COMP_W]) && $stable(rd_green) && $stable(rd_blue))));

  assert_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    other |=> ($stable(idx_q) && $stable(phase_q) &&
               (rd_idx != $past(rd_idx) || ($stable(rd_red) && $stable(rd_green) && $stable(rd_blue)))));
endmodule

bind palette_dac_port palette_dac_port_chk #(
  .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .IDX_OFF(IDX_OFF), .COL_OFF(COL_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_red(rd_red), .rd_green(rd_green), .rd_blue(rd_blue),
  .idx_q(idx_q), .phase_q(phase_q)
);

// File: tb/palette_dac_port_tb.sv
`timescale 1ns/1ps
module palette_dac_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_idx = '0;
  logic [7:0]  rd_red, rd_green, rd_blue;

  int vectors = 0;
  int errors  = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] midx;
  int         mph;

  always #2.5 clk = ~clk;

  palette_dac_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_red(rd_red), .rd_green(rd_green), .rd_blue(rd_blue)
  );

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic en);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_idx(input logic [7:0] v);
    bus_wr(4'h0, {v, 24'h13_57_9B}, 1'b1);
    midx = v; mph = 0;
  endtask

  task automatic put_comp(input logic [7:0] c);
    bus_wr(4'h4, {c, 24'hA5_5A_0F}, 1'b1);
    case (mph)
      0: begin mr[midx] = c; mph = 1; end
      1: begin mg[midx] = c; mph = 2; end
      default: begin mb[midx] = c; mph = 0; midx = midx + 8'd1; end
    endcase
  endtask

  task automatic check_entry(input int i, input string tag);
    rd_idx = 8'(i);
    #1;
    vectors++;
    if ({rd_red, rd_green, rd_blue} !== {mr[i], mg[i], mb[i]}) begin
      errors++;
      $display("FAIL %s entry %0d: got %h%h%h expected %h%h%h", tag, i,
               rd_red, rd_green, rd_blue, mr[i], mg[i], mb[i]);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 256; i++) check_entry(i, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 8'hFF : 8'h00;
      mg[i] = mr[i];
      mb[i] = mr[i];
    end
    midx = 0; mph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset contents; R8 combinational read while no clock edge separates samples
    check_all("R5/R8 reset");

    // R1 R3 R4: full table load from one index write, 768 component writes
    put_idx(8'd0);
    for (int i = 0; i < 256; i++) begin
      put_comp(8'(i) ^ 8'h5A);
      put_comp(8'(i * 3));
      put_comp(~8'(i));
    end
    check_all("R3/R4 full load");

    // R1: arbitrary start index, several entries
    put_idx(8'd100);
    for (int i = 0; i < 9; i++) put_comp(8'(8'hC0 + i));
    for (int i = 99; i <= 103; i++) check_entry(i, "R1 start index");

    // R4: wrap from 255 to 0
    put_idx(8'd255);
    put_comp(8'h11); put_comp(8'h22); put_comp(8'h33);
    put_comp(8'h44); put_comp(8'h55); put_comp(8'h66);
    check_entry(255, "R4 last entry");
    check_entry(0, "R4 wrap entry");
    check_entry(1, "R4 beyond wrap");

    // R6: partial triple visible immediately, other components kept
    put_idx(8'd40);
    put_comp(8'hAB);
    check_entry(40, "R6 red only");
    put_comp(8'hCD);
    check_entry(40, "R6 red+green");

    // R2: index write abandons triple; next colour write is red
    put_idx(8'd20);
    put_comp(8'h77);
    check_entry(20, "R2 fresh red");
    put_comp(8'h88);
    check_entry(20, "R2 green after restart");
    check_entry(40, "R2 old entry untouched");

    // R7: sweep unused offsets, and strobe low at the colour offset
    put_idx(8'd60);
    put_comp(8'h01);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4) bus_wr(4'(a), 32'hEE00_0000 | 32'(a), 1'b1);
    end
    bus_wr(4'h4, 32'hEF00_0000, 1'b0);
    bus_wr(4'h0, 32'h0300_0000, 1'b0);
    check_all("R7 ignored writes");
    put_comp(8'h02);
    put_comp(8'h03);
    put_comp(8'h04);
    check_entry(60, "R7 phase kept");
    check_entry(61, "R7 index kept");

    // R5 again: reset mid-triple restores defaults
    put_idx(8'd255);
    put_comp(8'h12);
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 8'hFF : 8'h00;
      mg[i] = mr[i];
      mb[i] = mr[i];
    end
    midx = 0; mph = 0;
    @(negedge clk); rst_n = 1'b1;
    check_all("R5 reset again");
    put_comp(8'h9C);
    check_entry(0, "R5 index and phase after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule